// File: doc/BRIEF.md
# Interrupt Pin Request and Delivery Logic

This block sits between a set of interrupt input pins and the processors' interrupt fabric. It keeps a pending-request bit for each pin and decides when a pin produces a delivery request. Each pin's trigger mode (edge or level), mask, vector and destination come from a routing table that lives outside the block. The block owns one piece of per-entry state, the remote-acknowledge bit, which it sets when a level-triggered request is accepted.

Line activity arrives as per-pin reports. A report carries a valid strobe and the line level. Pins that need service are queued and handled one at a time through a request/accept handshake. The accept carries a flag that says whether any target took the interrupt. A second edge on an edge-triggered pin whose request is still pending is merged into the first one, and that merge is signalled on a per-pin coalesced output. When the routing entry of a pin is rewritten, the block looks at that pin again. Register access and end-of-interrupt handling belong to other blocks.

Top module: `irq_pin_dispatch`

## Requirements
- R1: A low report on a pin clears its pending bit. The pending bit drops one clock edge after the report. Any attempt still queued for that pin is withdrawn and produces no request.
- R2: A high report on a pin sets its pending bit. The pin's `pend_o` bit reads 1 after the clock edge that samples the report.
- R3: A high report on an edge-triggered pin (trigger bit 0) whose pending bit is already set pulses `coal_o` for exactly one cycle. It causes no new delivery attempt.
- R4: A new high report on an edge-triggered pin clears that pin's delivered flag. Its `pend_o` bit therefore reads 1 again after that report, even if an earlier request was delivered.
- R5: An attempt is dropped without raising `dlv_req_o` when the entry is masked (mask bit 1). It is also dropped when the entry is level-triggered (trigger bit 1) and its remote-acknowledge bit is set.
- R6: When an edge-triggered request is issued, the delivered flag is set, and `pend_o` = pending bits with delivered edge requests removed. A level-triggered pin keeps `pend_o` at 1 while its pending bit is set.
- R7: An accept (`dlv_ack_i`=1) of a level-triggered request with `dlv_hit_i`=1 sets that pin's `rack_o` bit on the accept edge. An accept with `dlv_hit_i`=0 leaves it unchanged.
- R8: A rewrite strobe on a pin whose new entry is level-triggered and whose pending bit is set starts a delivery attempt for that pin.
- R9: A rewrite strobe whose new entry is edge-triggered clears that pin's `rack_o` bit.
- R10: When several pins need service, attempts are made one at a time, lowest pin index first.
- R11: A request raises `dlv_req_o` two clock edges after the report or rewrite that caused it. It carries the pin index, vector, destination and trigger mode (1 = level) of that pin. It holds all of them stable until `dlv_ack_i` is sampled high, and drops on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_vld_i | input | NUM_PINS | Per-pin line report strobe |
| rpt_lvl_i | input | NUM_PINS | Reported line level (1 = asserted) |
| cfg_trig_i | input | NUM_PINS | Routing entry trigger mode (0 edge, 1 level) |
| cfg_mask_i | input | NUM_PINS | Routing entry mask (1 = masked) |
| cfg_vec_i | input | NUM_PINS*VEC_W | Routing entry vectors, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dst_i | input | NUM_PINS*DST_W | Routing entry destinations, pin i at bits [i*DST_W +: DST_W] |
| cfg_wr_i | input | NUM_PINS | Per-pin strobe: routing entry rewritten this cycle |
| dlv_req_o | output | 1 | Delivery request valid |
| dlv_pin_o | output | PIN_W | Pin index of the request |
| dlv_vec_o | output | VEC_W | Vector of the request |
| dlv_dst_o | output | DST_W | Destination of the request |
| dlv_trig_o | output | 1 | Trigger mode of the request (1 = level) |
| dlv_ack_i | input | 1 | Request accepted this cycle |
| dlv_hit_i | input | 1 | At least one target took the request (valid with accept) |
| coal_o | output | NUM_PINS | One-cycle per-pin coalesced pulse |
| pend_o | output | NUM_PINS | Pending bits with delivered edge requests removed |
| rack_o | output | NUM_PINS | Per-pin remote-acknowledge bits |

## Verification
Inputs are driven at the falling edge and outputs are sampled at the next falling edge. After one step, `pend_o` and `coal_o` show the effect of a report. `coal_o` is low again one step later. `dlv_req_o` and its fields show up after the second step, when an edge-triggered pin also drops out of `pend_o`. The `rack_o` bits and the fall of `dlv_req_o` are checked one step after the step that held `dlv_ack_i` high. The sweep covers every pin in all four combinations of trigger mode and mask. It then walks a full-width burst to check the order of service, and finally checks that a queued attempt is withdrawn by a low report.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
  import irq_disp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rpt_vld_i,
  input  logic rpt_lvl_i,
  input  logic cfg_trig_i,
  input  logic cfg_mask_i,
  input  logic cfg_wr_i,
  input  logic pick_i,
  input  logic acc_hit_i,
  output logic need_o,
  output logic blk_o,
  output logic pend_o,
  output logic rack_o,
  output logic coal_o
);
  logic irr_q, dlvd_q, need_q, rack_q, coal_q;
  logic is_lvl, rise, fall, fire;

  assign is_lvl = (trig_e'(cfg_trig_i) == TRIG_LEVEL);
  assign rise   = rpt_vld_i & rpt_lvl_i;
  assign fall   = rpt_vld_i & ~rpt_lvl_i;
  assign blk_o  = cfg_mask_i | (is_lvl & rack_q);
  assign fire   = pick_i & ~blk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= 1'b0;
      dlvd_q <= 1'b0;
      need_q <= 1'b0;
      rack_q <= 1'b0;
      coal_q <= 1'b0;
    end else begin
      coal_q <= rise & ~is_lvl & irr_q;
      if (fall)      irr_q <= 1'b0;
      else if (rise) irr_q <= 1'b1;
      // a new edge invalidates the previous delivery
      if (rise & ~is_lvl)      dlvd_q <= 1'b0;
      else if (fire & ~is_lvl) dlvd_q <= 1'b1;
      if (fall)                                need_q <= 1'b0;
      else if (rise & (is_lvl | ~irr_q))       need_q <= 1'b1;
      else if (cfg_wr_i & is_lvl & irr_q)      need_q <= 1'b1;
      else if (pick_i)                         need_q <= 1'b0;
      if (cfg_wr_i & ~is_lvl) rack_q <= 1'b0;
      else if (acc_hit_i)     rack_q <= 1'b1;
    end
  end

  assign need_o = need_q;
  assign pend_o = irr_q & ~dlvd_q;
  assign rack_o = rack_q;
  assign coal_o = coal_q;

  // R1
  deassert_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> (!irr_q && !need_q));
  // R7
  rack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rack_q) |-> $past(acc_hit_i));
  // R3
  coalesce_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coal_q |-> irr_q);
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        grant_o[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  // R10
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R10
  grant_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ~req_i) == '0) && ((req_i != '0) == (grant_o != '0)));
endmodule

// File: rtl/irq_dlv_reg.sv
module irq_dlv_reg #(
  parameter int PIN_W = 3,
  parameter int VEC_W = 8,
  parameter int DST_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIN_W-1:0] pin_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [DST_W-1:0] dst_i,
  input  logic             trig_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [PIN_W-1:0] pin_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [DST_W-1:0] dst_o,
  output logic             trig_o
);
  logic             req_q, trig_q;
  logic [PIN_W-1:0] pin_q;
  logic [VEC_W-1:0] vec_q;
  logic [DST_W-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      trig_q <= 1'b0;
      pin_q  <= '0;
      vec_q  <= '0;
      dst_q  <= '0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (load_i) begin
      req_q  <= 1'b1;
      trig_q <= trig_i;
      pin_q  <= pin_i;
      vec_q  <= vec_i;
      dst_q  <= dst_i;
    end
  end

  assign req_o  = req_q;
  assign pin_o  = pin_q;
  assign vec_o  = vec_q;
  assign dst_o  = dst_q;
  assign trig_o = trig_q;

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable({pin_q, vec_q, dst_q, trig_q})));
  // R11
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i) |=> !req_q);
endmodule

// File: rtl/irq_pin_dispatch.sv
module irq_pin_dispatch #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DST_W    = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       rpt_vld_i,
  input  logic [NUM_PINS-1:0]       rpt_lvl_i,
  input  logic [NUM_PINS-1:0]       cfg_trig_i,
  input  logic [NUM_PINS-1:0]       cfg_mask_i,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vec_i,
  input  logic [NUM_PINS*DST_W-1:0] cfg_dst_i,
  input  logic [NUM_PINS-1:0]       cfg_wr_i,
  output logic                      dlv_req_o,
  output logic [PIN_W-1:0]          dlv_pin_o,
  output logic [VEC_W-1:0]          dlv_vec_o,
  output logic [DST_W-1:0]          dlv_dst_o,
  output logic                      dlv_trig_o,
  input  logic                      dlv_ack_i,
  input  logic                      dlv_hit_i,
  output logic [NUM_PINS-1:0]       coal_o,
  output logic [NUM_PINS-1:0]       pend_o,
  output logic [NUM_PINS-1:0]       rack_o
);
  logic [NUM_PINS-1:0] need, blk, grant, cand, acc_hit;
  logic                issue, sel_trig;
  logic [PIN_W-1:0]    sel_pin;
  logic [VEC_W-1:0]    sel_vec;
  logic [DST_W-1:0]    sel_dst;

  // no new pick while a request is outstanding
  assign cand  = need & {NUM_PINS{~dlv_req_o}};
  assign issue = |(grant & ~blk);

  irq_low_pick #(.N(NUM_PINS)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (cand),
    .grant_o (grant)
  );

  always_comb begin
    sel_pin  = '0;
    sel_vec  = '0;
    sel_dst  = '0;
    sel_trig = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (grant[i]) begin
        sel_pin  = PIN_W'(i);
        sel_vec  = cfg_vec_i[i*VEC_W +: VEC_W];
        sel_dst  = cfg_dst_i[i*DST_W +: DST_W];
        sel_trig = cfg_trig_i[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign acc_hit[g] = dlv_req_o & dlv_ack_i & dlv_hit_i & dlv_trig_o
                      & (dlv_pin_o == PIN_W'(g));
    irq_pin_ctl u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rpt_vld_i  (rpt_vld_i[g]),
      .rpt_lvl_i  (rpt_lvl_i[g]),
      .cfg_trig_i (cfg_trig_i[g]),
      .cfg_mask_i (cfg_mask_i[g]),
      .cfg_wr_i   (cfg_wr_i[g]),
      .pick_i     (grant[g]),
      .acc_hit_i  (acc_hit[g]),
      .need_o     (need[g]),
      .blk_o      (blk[g]),
      .pend_o     (pend_o[g]),
      .rack_o     (rack_o[g]),
      .coal_o     (coal_o[g])
    );
  end

  irq_dlv_reg #(.PIN_W(PIN_W), .VEC_W(VEC_W), .DST_W(DST_W)) u_dlv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue),
    .pin_i  (sel_pin),
    .vec_i  (sel_vec),
    .dst_i  (sel_dst),
    .trig_i (sel_trig),
    .ack_i  (dlv_ack_i),
    .req_o  (dlv_req_o),
    .pin_o  (dlv_pin_o),
    .vec_o  (dlv_vec_o),
    .dst_o  (dlv_dst_o),
    .trig_o (dlv_trig_o)
  );

  // R5
  masked_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlv_req_o) |-> !$past(cfg_mask_i[dlv_pin_o]));
endmodule

// File: tb/irq_pin_dispatch_bench.sv
`timescale 1ns/1ps
module irq_pin_dispatch_bench;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rpt_vld = '0, rpt_lvl = '0, cfg_trig = '0, cfg_mask = '0, cfg_wr = '0;
  logic [N*VW-1:0] cfg_vec;
  logic [N*DW-1:0] cfg_dst;
  logic dlv_ack = 1'b0, dlv_hit = 1'b0;
  logic dlv_req, dlv_trig;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vec;
  logic [DW-1:0] dlv_dst;
  logic [N-1:0] coal, pend, rack;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_pin_dispatch #(.NUM_PINS(N), .VEC_W(VW), .DST_W(DW)) u_irq_pin_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .rpt_vld_i(rpt_vld), .rpt_lvl_i(rpt_lvl),
    .cfg_trig_i(cfg_trig), .cfg_mask_i(cfg_mask),
    .cfg_vec_i(cfg_vec), .cfg_dst_i(cfg_dst), .cfg_wr_i(cfg_wr),
    .dlv_req_o(dlv_req), .dlv_pin_o(dlv_pin), .dlv_vec_o(dlv_vec),
    .dlv_dst_o(dlv_dst), .dlv_trig_o(dlv_trig),
    .dlv_ack_i(dlv_ack), .dlv_hit_i(dlv_hit),
    .coal_o(coal), .pend_o(pend), .rack_o(rack)
  );

  function automatic int exp_vec(int p); return (16 * p + 3) % 256; endfunction
  function automatic int exp_dst(int p); return (5 * p + 1) % 256; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report(input int p, input bit lvl);
    rpt_vld[p] = 1'b1;
    rpt_lvl[p] = lvl;
    step();
    rpt_vld[p] = 1'b0;
  endtask

  task automatic rewrite(input int p, input bit trig, input bit mask);
    cfg_trig[p] = trig;
    cfg_mask[p] = mask;
    cfg_wr[p]   = 1'b1;
    step();
    cfg_wr[p]   = 1'b0;
  endtask

  task automatic accept(input bit hit);
    dlv_ack = 1'b1;
    dlv_hit = hit;
    step();
    dlv_ack = 1'b0;
    dlv_hit = 1'b0;
  endtask

  task automatic scen(input int p, input bit m, input bit k);
    report(p, 0);
    rewrite(p, 0, 1);
    chk("R9 rack cleared by edge rewrite", rack[p], 0);
    rewrite(p, m, k);
    report(p, 1);
    chk("R2 pend after high report", pend[p], 1);
    chk("R3 no coalesce on first edge", coal[p], 0);
    step();
    chk("R5 req only when unmasked", dlv_req, !k);
    if (!k) begin
      chk("R11 req pin", dlv_pin, p);
      chk("R11 req vector", dlv_vec, exp_vec(p));
      chk("R11 req dest", dlv_dst, exp_dst(p));
      chk("R11 req trig", dlv_trig, m);
      chk("R6 pend after issue", pend[p], m);
      accept(1);
      chk("R11 req drops on accept", dlv_req, 0);
      chk("R7 rack after accepted", rack[p], m);
    end else begin
      chk("R5 masked keeps pend", pend[p], 1);
    end
    report(p, 1);
    chk("R3 coalesced pulse", coal[p], !m);
    chk("R4 pend after new report", pend[p], 1);
    step();
    chk("R3 pulse one cycle", coal[p], 0);
    chk("R5 R3 no second req", dlv_req, 0);
    rewrite(p, 0, 1);
    chk("R9 rack clear", rack[p], 0);
    step();
    chk("R9 edge rewrite no req", dlv_req, 0);
    rewrite(p, 1, 0);
    step();
    chk("R8 rewrite level pending req", dlv_req, 1);
    chk("R8 rewrite req pin", dlv_pin, p);
    chk("R8 rewrite req trig", dlv_trig, 1);
    accept(0);
    chk("R7 no hit leaves rack", rack[p], 0);
    report(p, 0);
    chk("R1 pend cleared", pend[p], 0);
    step();
    chk("R1 no req after low", dlv_req, 0);
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin
      cfg_vec[p*VW +: VW] = VW'(exp_vec(p));
      cfg_dst[p*DW +: DW] = DW'(exp_dst(p));
    end
    step();
    step();
    rst_n = 1'b1;
    step();
    chk("R11 reset req", dlv_req, 0);
    chk("R2 reset pend", pend, 0);
    chk("R7 reset rack", rack, 0);
    chk("R3 reset coal", coal, 0);

    for (int p = 0; p < N; p++)
      for (int mode = 0; mode < 4; mode++)
        scen(p, mode[0], mode[1]);

    // full burst, edge, unmasked
    cfg_trig = '0;
    cfg_mask = '0;
    cfg_wr   = '1;
    step();
    cfg_wr   = '0;
    rpt_vld = '1;
    rpt_lvl = '1;
    step();
    rpt_vld = '0;
    for (int i = 0; i < N; i++) begin
      step();
      chk("R10 req present", dlv_req, 1);
      chk("R10 lowest first", dlv_pin, i);
      if (i == 0) begin
        for (int w = 0; w < 3; w++) begin
          step();
          chk("R11 held req", dlv_req, 1);
          chk("R11 held pin", dlv_pin, 0);
          chk("R11 held vec", dlv_vec, exp_vec(0));
        end
      end
      accept(1);
      chk("R11 dropped", dlv_req, 0);
    end
    chk("R6 all edges delivered", pend, 0);
    rpt_vld = '1;
    rpt_lvl = '0;
    step();
    rpt_vld = '0;

    // queued attempt withdrawn
    rpt_vld = 8'b0010_0100;
    rpt_lvl = 8'b0010_0100;
    step();
    rpt_vld = '0;
    step();
    chk("R10 pin2 first", dlv_pin, 2);
    report(5, 0);
    accept(1);
    for (int w = 0; w < 3; w++) begin
      step();
      chk("R1 withdrawn no req", dlv_req, 0);
    end
    chk("R1 pend pin5", pend[5], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule